// File: doc/BRIEF.md
# Single-Bit Memory Instruction Executor

This block carries out instructions that act on one bit of a byte held in data memory. It is given an already decoded instruction: an operation code, an addressing class, a bit index, an operand address, a signed 8-bit relative offset, the address of the instruction itself, and the current accumulator with its N and Z flags. It then runs the memory accesses through a byte-wide port. Where the instruction calls for it, it reads, modifies and writes back the addressed byte. It finishes each form after a fixed number of cycles. That number depends on the operation, on the addressing class and, for branches, on whether the branch is taken.

The operations are: loading a bit into the accumulator; storing accumulator bit 0 into a memory bit; setting or clearing a bit; branching on a clear bit or on a set bit; an atomic test-and-set that branches on the old value; and waiting, with no time limit, until an I/O bit reads as set or as clear. At the end of each instruction the block presents the accumulator, N and Z, a branch-taken indication and the address where execution continues, together with a one-cycle done strobe. Instruction fetch and the program counter belong to the surrounding core. The block asks only for memory with a one-cycle read latency.

Top module: `bitop_exec`

## Requirements
- R1: Operation codes are 0 load bit, 1 store bit, 2 set bit, 3 clear bit, 4 branch if clear, 5 branch if set, 6 test-and-set branch, 7 wait until set, 8 wait until clear. Addressing class codes are 0 short direct, 1 absolute, 2 I/O, and 3 is reserved. While idle, a start with a legal pair is accepted and busy is high in the next cycle. A start is ignored, with busy staying low and no memory access, for class 3, for codes 9 to 15, for test-and-set outside class 1, and for either wait outside class 2.
- R2: Load bit sets accumulator bits 7..0 to the addressed memory bit in bit 0 and zeros in bits 7..1. Accumulator bits 15..8 are unchanged. N becomes 0, and Z becomes 1 exactly when the bit was 0.
- R3: Store bit writes accumulator bit 0 into the addressed bit and leaves the other seven bits of the byte unchanged. N becomes 0, and Z becomes 1 exactly when accumulator bit 0 is 0.
- R4: Set bit writes the addressed bit to 1 and clear bit writes it to 0. Both leave the other bits of the byte, the accumulator, N and Z unchanged.
- R5: Branch if clear is taken when the bit is 0, and branch if set is taken when it is 1. Z becomes 1 exactly when the bit is 0, and N is unchanged.
- R6: Test-and-set branch is taken when the old bit is 1 and always writes the bit to 1. Z reflects the old bit as in R5.
- R7: A wait reads the addressed byte every cycle until the bit matches: 1 for wait until set, 0 for wait until clear. If read number j is the first that matches, the instruction lasts j+2 cycles. The accumulator, N and Z are unchanged.
- R8: The instruction lasts as follows. Load takes 5 cycles in class 0 or 1 and 4 in class 2. Store takes 7 in class 0 or 1 and 6 in class 2. Set and clear take 7 in every class. Branch if clear takes 8 taken and 7 not taken in class 0 or 1, and 7 and 6 in class 2. Branch if set takes 8 and 7. Test-and-set takes 10 and 9.
- R9: The continuation address is the instruction address plus its length, plus the sign-extended offset when the branch is taken, all modulo 2^16. The length is 3 bytes in classes 0 and 2 and 4 bytes in class 1, with one more byte for the branch forms (codes 4 to 6).
- R10: A read-modify-write form (codes 1, 2, 3, 6) issues exactly one read and, in the next cycle, exactly one write to the same address and space. No other code ever writes.
- R11: An instruction of C cycles keeps busy high for C cycles. Done is high only in the last of them. The results stay on the outputs after done until the next instruction is accepted.
- R12: The space output carries the addressing class. The address output is the full 16-bit operand in class 1, and the low 8 operand bits zero-extended in classes 0 and 2.
- R13: After reset, busy, done, read and write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an instruction (sampled while idle) |
| op_i | input | 4 | Operation code |
| mode_i | input | 2 | Addressing class |
| bit_i | input | 3 | Bit index within the byte |
| addr_i | input | 16 | Operand address |
| rel_i | input | 8 | Signed branch offset |
| pc_i | input | 16 | Address of the instruction |
| acc_i | input | 16 | Accumulator before the instruction |
| n_i | input | 1 | N flag before the instruction |
| z_i | input | 1 | Z flag before the instruction |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_space_o | output | 2 | Address space of the access |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the read strobe |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Last cycle of the instruction |
| acc_o | output | 16 | Resulting accumulator |
| n_o | output | 1 | Resulting N flag |
| z_o | output | 1 | Resulting Z flag |
| taken_o | output | 1 | Branch was taken |
| npc_o | output | 16 | Continuation address |

## Verification
The assertions assume that memory returns read data in the cycle after each read strobe and that start is a pulse given only while busy is low. The bench meets both with a registered-read memory model and single-cycle start pulses driven on the falling edge. The wait checks also assume that a matching value eventually appears. The bench guarantees this for the wait vectors by inverting the polled bit on a chosen read, so every wait ends within a few polls.

// File: rtl/bitx_pkg.sv
package bitx_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [3:0] {
        OP_LDB  = 4'd0,
        OP_STB  = 4'd1,
        OP_SETB = 4'd2,
        OP_CLRB = 4'd3,
        OP_BRC  = 4'd4,
        OP_BRS  = 4'd5,
        OP_TSB  = 4'd6,
        OP_WTS  = 4'd7,
        OP_WTC  = 4'd8
    } bop_e;

    typedef enum logic [1:0] {
        AM_DIR = 2'd0,
        AM_ABS = 2'd1,
        AM_IO  = 2'd2,
        AM_RSV = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_EV   = 3'd2,
        ST_HOLD = 3'd3,
        ST_DONE = 3'd4
    } st_e;

    // cycle budgets per form
    localparam logic [CNT_W-1:0] CYC_LD_MEM    = CNT_W'(5);
    localparam logic [CNT_W-1:0] CYC_LD_IO     = CNT_W'(4);
    localparam logic [CNT_W-1:0] CYC_ST_MEM    = CNT_W'(7);
    localparam logic [CNT_W-1:0] CYC_ST_IO     = CNT_W'(6);
    localparam logic [CNT_W-1:0] CYC_RMW       = CNT_W'(7);
    localparam logic [CNT_W-1:0] CYC_BR_NT     = CNT_W'(7);
    localparam logic [CNT_W-1:0] CYC_BRC_IO_NT = CNT_W'(6);
    localparam logic [CNT_W-1:0] CYC_TS_NT     = CNT_W'(9);
    localparam logic [CNT_W-1:0] CYC_TAKEN_ADD = CNT_W'(1);

    localparam logic [2:0] LEN_SHORT = 3'd3;
    localparam logic [2:0] LEN_LONG  = 3'd4;

    typedef struct packed {
        logic             rmw;
        logic             branch;
        logic             poll;
        logic [2:0]       len;
        logic [CNT_W-1:0] cyc_nt;
        logic [CNT_W-1:0] cyc_tk;
    } dec_t;

endpackage

// File: rtl/bitx_decode.sv
module bitx_decode
    import bitx_pkg::*;
(
    input  logic [3:0] op_i,
    input  logic [1:0] mode_i,
    output logic       legal_o,
    output dec_t       dec_o
);

    logic is_io;
    logic is_abs;
    logic is_rsv;
    logic [2:0] base_len;

    always_comb begin
        is_io    = (mode_i == AM_IO);
        is_abs   = (mode_i == AM_ABS);
        is_rsv   = (mode_i == AM_RSV);
        base_len = is_abs ? LEN_LONG : LEN_SHORT;

        legal_o  = 1'b0;
        dec_o    = '0;
        dec_o.len = base_len;

        case (op_i)
            OP_LDB: begin
                legal_o      = !is_rsv;
                dec_o.cyc_nt = is_io ? CYC_LD_IO : CYC_LD_MEM;
            end
            OP_STB: begin
                legal_o      = !is_rsv;
                dec_o.rmw    = 1'b1;
                dec_o.cyc_nt = is_io ? CYC_ST_IO : CYC_ST_MEM;
            end
            OP_SETB, OP_CLRB: begin
                legal_o      = !is_rsv;
                dec_o.rmw    = 1'b1;
                dec_o.cyc_nt = CYC_RMW;
            end
            OP_BRC: begin
                legal_o      = !is_rsv;
                dec_o.branch = 1'b1;
                dec_o.len    = base_len + 3'd1;
                dec_o.cyc_nt = is_io ? CYC_BRC_IO_NT : CYC_BR_NT;
            end
            OP_BRS: begin
                legal_o      = !is_rsv;
                dec_o.branch = 1'b1;
                dec_o.len    = base_len + 3'd1;
                dec_o.cyc_nt = CYC_BR_NT;
            end
            OP_TSB: begin
                legal_o      = is_abs;
                dec_o.rmw    = 1'b1;
                dec_o.branch = 1'b1;
                dec_o.len    = base_len + 3'd1;
                dec_o.cyc_nt = CYC_TS_NT;
            end
            OP_WTS, OP_WTC: begin
                legal_o    = is_io;
                dec_o.poll = 1'b1;
            end
            default: legal_o = 1'b0;
        endcase

        dec_o.cyc_tk = dec_o.cyc_nt + CYC_TAKEN_ADD;
    end

endmodule

// File: rtl/bitx_bitalu.sv
module bitx_bitalu
    import bitx_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int RW = 8,
    localparam int BW = $clog2(DW)
) (
    input  bop_e          op_i,
    input  logic [BW-1:0] bidx_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          acc0_i,
    input  logic [AW-1:0] pc_i,
    input  logic [RW-1:0] rel_i,
    input  logic [2:0]    len_i,
    input  logic          taken_i,
    output logic          bitv_o,
    output logic          cond_o,
    output logic [DW-1:0] wdata_o,
    output logic [AW-1:0] npc_o
);

    logic [DW-1:0] mask;
    logic [AW-1:0] rel_sx;
    logic [AW-1:0] seq_pc;

    always_comb begin
        mask   = DW'(1) << bidx_i;
        bitv_o = rdata_i[bidx_i];

        case (op_i)
            OP_BRC, OP_WTC: cond_o = !bitv_o;
            default:        cond_o = bitv_o;
        endcase

        case (op_i)
            OP_STB:         wdata_o = acc0_i ? (rdata_i | mask) : (rdata_i & ~mask);
            OP_SETB, OP_TSB: wdata_o = rdata_i | mask;
            OP_CLRB:        wdata_o = rdata_i & ~mask;
            default:        wdata_o = rdata_i;
        endcase

        rel_sx = {{(AW-RW){rel_i[RW-1]}}, rel_i};
        seq_pc = pc_i + AW'(len_i);
        npc_o  = taken_i ? (seq_pc + rel_sx) : seq_pc;
    end

endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
    import bitx_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int XW = 16,
    parameter int RW = 8,
    parameter int SW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [3:0]    op_i,
    input  logic [1:0]    mode_i,
    input  logic [BW-1:0] bit_i,
    input  logic [AW-1:0] addr_i,
    input  logic [RW-1:0] rel_i,
    input  logic [AW-1:0] pc_i,
    input  logic [XW-1:0] acc_i,
    input  logic          n_i,
    input  logic          z_i,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [1:0]    mem_space_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [XW-1:0] acc_o,
    output logic          n_o,
    output logic          z_o,
    output logic          taken_o,
    output logic [AW-1:0] npc_o
);

    typedef struct packed {
        st_e              st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] limit;
        dec_t             dec;
        bop_e             op;
        amode_e           mode;
        logic [BW-1:0]    bidx;
        logic [AW-1:0]    addr;
        logic [AW-1:0]    pc;
        logic [RW-1:0]    rel;
        logic [XW-1:0]    acc;
        logic             n;
        logic             z;
        logic             taken;
        logic [AW-1:0]    npc;
    } state_t;

    state_t s_d, s_q;

    logic          legal_in;
    dec_t          dec_in;
    logic          bitv;
    logic          cond;
    logic          taken_now;
    logic [DW-1:0] wdata;
    logic [AW-1:0] npc_calc;

    bitx_decode u_dec (
        .op_i    (op_i),
        .mode_i  (mode_i),
        .legal_o (legal_in),
        .dec_o   (dec_in)
    );

    assign taken_now = s_q.dec.branch && cond;

    bitx_bitalu #(.AW(AW), .DW(DW), .RW(RW)) u_alu (
        .op_i    (s_q.op),
        .bidx_i  (s_q.bidx),
        .rdata_i (mem_rdata_i),
        .acc0_i  (s_q.acc[0]),
        .pc_i    (s_q.pc),
        .rel_i   (s_q.rel),
        .len_i   (s_q.dec.len),
        .taken_i (taken_now),
        .bitv_o  (bitv),
        .cond_o  (cond),
        .wdata_o (wdata),
        .npc_o   (npc_calc)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i && legal_in) begin
                    s_d.st    = ST_RD;
                    s_d.cnt   = CNT_W'(1);
                    s_d.limit = '0;
                    s_d.dec   = dec_in;
                    s_d.op    = bop_e'(op_i);
                    s_d.mode  = amode_e'(mode_i);
                    s_d.bidx  = bit_i;
                    s_d.addr  = addr_i;
                    s_d.pc    = pc_i;
                    s_d.rel   = rel_i;
                    s_d.acc   = acc_i;
                    s_d.n     = n_i;
                    s_d.z     = z_i;
                    s_d.taken = 1'b0;
                end
            end
            ST_RD: begin
                s_d.st  = ST_EV;
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
            ST_EV: begin
                s_d.npc = npc_calc;
                if (s_q.dec.poll) begin
                    if (cond) begin
                        s_d.st = ST_DONE;
                    end
                end else begin
                    s_d.st    = ST_HOLD;
                    s_d.cnt   = s_q.cnt + CNT_W'(1);
                    s_d.taken = taken_now;
                    s_d.limit = taken_now ? s_q.dec.cyc_tk : s_q.dec.cyc_nt;
                    case (s_q.op)
                        OP_LDB: begin
                            s_d.acc[DW-1:0] = {{(DW-1){1'b0}}, bitv};
                            s_d.n           = 1'b0;
                            s_d.z           = !bitv;
                        end
                        OP_STB: begin
                            s_d.n = 1'b0;
                            s_d.z = !s_q.acc[0];
                        end
                        OP_BRC, OP_BRS, OP_TSB: begin
                            s_d.z = !bitv;
                        end
                        default: ;
                    endcase
                end
            end
            ST_HOLD: begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
                if (s_q.cnt == s_q.limit - CNT_W'(1)) begin
                    s_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_rd_o    = (s_q.st == ST_RD) ||
                         ((s_q.st == ST_EV) && s_q.dec.poll && !cond);
    assign mem_wr_o    = (s_q.st == ST_EV) && s_q.dec.rmw;
    assign mem_space_o = s_q.mode;
    assign mem_addr_o  = (s_q.mode == AM_ABS) ? s_q.addr
                                              : {{(AW-SW){1'b0}}, s_q.addr[SW-1:0]};
    assign mem_wdata_o = wdata;
    assign busy_o      = (s_q.st != ST_IDLE);
    assign done_o      = (s_q.st == ST_DONE);
    assign acc_o       = s_q.acc;
    assign n_o         = s_q.n;
    assign z_o         = s_q.z;
    assign taken_o     = s_q.taken;
    assign npc_o       = s_q.npc;

endmodule

// File: rtl/bitx_chk.sv
module bitx_chk
    import bitx_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [3:0]    op_i,
    input logic [1:0]    mode_i,
    input logic [BW-1:0] bit_i,
    input logic          n_i,
    input logic          z_i,
    input logic          mem_rd_o,
    input logic          mem_wr_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_rdata_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          n_o,
    input logic          z_o
);

    logic [3:0]    cap_op;
    logic [1:0]    cap_mode;
    logic [BW-1:0] cap_bit;
    logic          cap_n;
    logic          cap_z;
    logic [7:0]    cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_op   <= '0;
            cap_mode <= '0;
            cap_bit  <= '0;
            cap_n    <= 1'b0;
            cap_z    <= 1'b0;
            cyc      <= '0;
        end else begin
            if (start_i && !busy_o) begin
                cap_op   <= op_i;
                cap_mode <= mode_i;
                cap_bit  <= bit_i;
                cap_n    <= n_i;
                cap_z    <= z_i;
            end
            if (!busy_o) begin
                cyc <= 8'd1;
            end else if (cyc != 8'hFF) begin
                cyc <= cyc + 8'd1;
            end
        end
    end

    // R10
    rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> ($past(mem_rd_o) && $stable(mem_addr_o)));

    // R10
    no_rdwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    // R10
    wr_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (cap_op == OP_STB || cap_op == OP_SETB ||
                      cap_op == OP_CLRB || cap_op == OP_TSB));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R1
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && op_i == OP_LDB && mode_i != AM_RSV) |=> busy_o);

    // R8
    ld_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_op == OP_LDB) |-> (cyc == ((cap_mode == AM_IO) ? 8'd4 : 8'd5)));

    // R4
    setclr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (cap_op == OP_SETB || cap_op == OP_CLRB)) |-> (n_o == cap_n && z_o == cap_z));

    // R7
    wait_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_op == OP_WTS) |-> $past(mem_rdata_i[cap_bit]));

endmodule

bind bitop_exec bitx_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .op_i        (op_i),
    .mode_i      (mode_i),
    .bit_i       (bit_i),
    .n_i         (n_i),
    .z_i         (z_i),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .n_o         (n_o),
    .z_o         (z_o)
);

// File: tb/bitop_exec_tb.sv
module bitop_exec_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  mode_i = '0;
    logic [2:0]  bit_i = '0;
    logic [15:0] addr_i = '0;
    logic [7:0]  rel_i = '0;
    logic [15:0] pc_i = '0;
    logic [15:0] acc_i = '0;
    logic        n_i = 1'b0;
    logic        z_i = 1'b0;
    logic        mem_rd_o, mem_wr_o;
    logic [1:0]  mem_space_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;
    logic        busy_o, done_o;
    logic [15:0] acc_o;
    logic        n_o, z_o, taken_o;
    logic [15:0] npc_o;

    logic [7:0]  mem [0:1023];
    logic        poke_en = 1'b0;
    logic [9:0]  poke_idx = '0;
    logic [7:0]  poke_val = '0;
    logic [7:0]  flip_mask = '0;
    int          flip_at = -1;
    int          rd_cnt = 0;

    int vectors = 0;
    int fails = 0;
    int wd_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_exec u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .mode_i(mode_i),
        .bit_i(bit_i), .addr_i(addr_i), .rel_i(rel_i), .pc_i(pc_i), .acc_i(acc_i),
        .n_i(n_i), .z_i(z_i), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_space_o(mem_space_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o), .acc_o(acc_o),
        .n_o(n_o), .z_o(z_o), .taken_o(taken_o), .npc_o(npc_o)
    );

    // memory model: registered read, one-cycle latency
    always @(posedge clk) begin
        if (poke_en) mem[poke_idx] <= poke_val;
        if (mem_wr_o) mem[{mem_space_o, mem_addr_o[7:0]}] <= mem_wdata_o;
        if (mem_rd_o) begin
            rd_cnt <= rd_cnt + 1;
            if (rd_cnt + 1 == flip_at) begin
                mem[{mem_space_o, mem_addr_o[7:0]}] <= mem[{mem_space_o, mem_addr_o[7:0]}] ^ flip_mask;
                mem_rdata_i <= mem[{mem_space_o, mem_addr_o[7:0]}] ^ flip_mask;
            end else begin
                mem_rdata_i <= mem[{mem_space_o, mem_addr_o[7:0]}];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_vec(input int op, input int md, input int b, input logic [7:0] data,
                           input logic [15:0] acc, input logic nf, input logic zf,
                           input logic [15:0] addr, input logic [15:0] pc,
                           input logic [7:0] rel, input int wk);
        logic        bv;
        logic        want;
        int          ecyc;
        logic [15:0] eacc;
        logic        en, ez, et;
        logic [7:0]  emem;
        int          elen;
        int          ewr;
        logic [15:0] enpc;
        logic [15:0] eaddr;
        logic [9:0]  idx;
        int          k;
        int          nwr;
        string       tag;

        bv   = data[b];
        eacc = acc; en = nf; ez = zf; et = 1'b0; emem = data; ewr = 0;
        elen = (md == 1) ? 4 : 3;
        eaddr = (md == 1) ? addr : {8'h00, addr[7:0]};
        idx  = {md[1:0], addr[7:0]};
        want = 1'b0;
        ecyc = 0;
        tag  = "R8";
        case (op)
            0: begin ecyc = (md == 2) ? 4 : 5; eacc[7:0] = {7'b0, bv}; en = 1'b0; ez = !bv; tag = "R2"; end
            1: begin ecyc = (md == 2) ? 6 : 7; emem[b] = acc[0]; en = 1'b0; ez = !acc[0]; ewr = 1; tag = "R3"; end
            2: begin ecyc = 7; emem[b] = 1'b1; ewr = 1; tag = "R4"; end
            3: begin ecyc = 7; emem[b] = 1'b0; ewr = 1; tag = "R4"; end
            4: begin elen++; et = !bv; ez = !bv; ecyc = ((md == 2) ? 6 : 7) + int'(et); tag = "R5"; end
            5: begin elen++; et = bv; ez = !bv; ecyc = 7 + int'(et); tag = "R5"; end
            6: begin elen++; et = bv; ez = !bv; ecyc = 9 + int'(et); emem[b] = 1'b1; ewr = 1; tag = "R6"; end
            default: begin
                want = (op == 7);
                tag = "R7";
                ecyc = (bv == want) ? 3 : wk + 2;
                emem[b] = want;
            end
        endcase
        enpc = pc + 16'(elen) + (et ? {{8{rel[7]}}, rel} : 16'h0000);

        @(negedge clk);
        poke_en = 1'b1; poke_idx = idx; poke_val = data;
        @(negedge clk);
        poke_en = 1'b0;
        flip_mask = 8'(1) << b;
        flip_at = (op >= 7 && bv != want) ? rd_cnt + wk : -1;
        start_i = 1'b1; op_i = 4'(op); mode_i = 2'(md); bit_i = 3'(b);
        addr_i = addr; rel_i = rel; pc_i = pc; acc_i = acc; n_i = nf; z_i = zf;
        @(negedge clk);
        start_i = 1'b0;
        k = 1; nwr = 0;
        while (1) begin
            if (mem_rd_o || mem_wr_o) begin
                chk("R12 addr", {14'b0, mem_space_o, mem_addr_o}, {14'b0, 2'(md), eaddr});
            end
            if (mem_wr_o) nwr++;
            if (done_o || k > 40) break;
            @(negedge clk);
            k++;
        end
        chk({tag, " R8 cycles"}, 32'(k), 32'(ecyc));
        chk({tag, " acc"}, {16'b0, acc_o}, {16'b0, eacc});
        chk({tag, " N"}, {31'b0, n_o}, {31'b0, en});
        chk({tag, " Z"}, {31'b0, z_o}, {31'b0, ez});
        chk({tag, " taken"}, {31'b0, taken_o}, {31'b0, et});
        chk("R9 npc", {16'b0, npc_o}, {16'b0, enpc});
        chk({tag, " R10 mem"}, {24'b0, mem[idx]}, {24'b0, emem});
        chk("R10 writes", 32'(nwr), 32'(ewr));
        @(negedge clk);
        chk("R11 idle", {30'b0, busy_o, done_o}, 32'b0);
        chk("R11 held", {16'b0, acc_o}, {16'b0, eacc});
    endtask

    task automatic try_illegal(input int op, input int md);
        @(negedge clk);
        start_i = 1'b1; op_i = 4'(op); mode_i = 2'(md); bit_i = 3'd2;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 ignored", {30'b0, busy_o, mem_rd_o}, 32'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            wd_fail = 1;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails + wd_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R13 reset", {28'b0, busy_o, done_o, mem_rd_o, mem_wr_o}, 32'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 after release", {28'b0, busy_o, done_o, mem_rd_o, mem_wr_o}, 32'b0);

        for (int op = 0; op < 9; op++) begin
            for (int md = 0; md < 3; md++) begin
                if (op == 6 && md != 1) continue;
                if (op >= 7 && md != 2) continue;
                for (int b = 0; b < 8; b++) begin
                    for (int ds = 0; ds < 2; ds++) begin
                        for (int a0 = 0; a0 < 2; a0++) begin
                            logic [7:0] lo;
                            lo = 8'(b * 29 + op * 7 + md * 3 + ds);
                            run_vec(op, md, b, ds[0] ? 8'hA5 : 8'h5A,
                                    {8'h3C, 7'b1011001, a0[0]}, ds[0] ^ a0[0], b[0],
                                    {8'hE7 ^ 8'(op), lo}, 16'hFFF6 + 16'(b * 2 + a0),
                                    8'(128 + b * 37 + op * 13 + ds * 64), 2 + a0);
                        end
                    end
                end
            end
        end

        // R1 illegal combinations
        for (int op = 0; op < 9; op++) try_illegal(op, 3);
        try_illegal(6, 0);
        try_illegal(6, 2);
        try_illegal(7, 0);
        try_illegal(7, 1);
        try_illegal(8, 0);
        try_illegal(8, 1);
        for (int op = 9; op < 16; op++) try_illegal(op, 0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails + wd_fail);
        $finish;
    end

endmodule